// File: doc/BRIEF.md
# Processor-Written Configuration Byte Loader

This block lets a host processor push configuration data into a device one byte at a time, with ordinary peripheral writes. A write is recognised when both chip selects are active and the write strobe rises. The byte is then loaded into a shift register and sent out on an internal serial stream, one bit per clock, most significant bit first. Each bit comes with a valid strobe.

The host paces itself on a ready/busy output. While a byte is still being sent, the output shows busy. The host waits until it shows ready before it writes the next byte. Writes that arrive while the block is busy are dropped, and they set a sticky overrun flag so the host can tell that data was lost. No queue sits between the host and the serializer, so one byte is in flight at any time.

Top module: `cfg_byte_loader`

## Requirements
- R1: After reset is asserted, ready_o is 1, bit_vld_o is 0, bit_o is 0 and overrun_o is 0.
- R2: A write is recognised only in a cycle where wr_i is 1 while it was 0 in the previous cycle, with cs_i = 1 and cs_ni = 0 in that same cycle. A strobe edge with either select inactive has no effect. A strobe that was already high when the selects become valid also has no effect. In both cases ready_o stays 1 and bit_vld_o stays 0.
- R3: A write strobe held high over many cycles loads its byte only once. After that byte has been sent, ready_o stays 1 for as long as the strobe stays high.
- R4: ready_o goes to 0 in the cycle that follows the clock edge that captured a byte.
- R5: ready_o stays 0 for exactly 8 cycles and then returns to 1. bit_vld_o is 1 in exactly those 8 cycles.
- R6: In the k-th busy cycle (k = 0 to 7), bit_o equals bit 7-k of the captured byte, so bit 7 is sent first.
- R7: A write recognised while ready_o is 0 does not change the byte being sent. It sets overrun_o to 1, and overrun_o stays 1 until reset.
- R8: Reset asserted in the middle of a byte ends that byte at once: ready_o is 1, bit_vld_o is 0 and overrun_o is 0.
- R9: A write whose strobe rises in the first cycle after ready_o returns to 1 is accepted and sent in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| cs_ni | input | 1 | Chip select, active low |
| wr_i | input | 1 | Write strobe, active high, acted on at its rising edge |
| data_i | input | 8 | Configuration byte from the host |
| ready_o | output | 1 | 1 = ready for the next byte, 0 = busy |
| bit_o | output | 1 | Serial configuration bit |
| bit_vld_o | output | 1 | Marks a valid bit on bit_o |
| overrun_o | output | 1 | Sticky flag: a write was dropped while busy |

## Verification
The assertions check four rules on every cycle:
- one strobe edge gives no more than one write event;
- a load turns the block busy on the next cycle, and the last bit count releases it;
- each shifted bit is the one that sat next below the previous bit;
- a write during busy sets the overrun flag, which then never clears.

Other behaviour shows only in the bench scenarios, which compare outputs against expected bit sequences:
- the full ordering of the bits in a byte;
- that select combinations and a held strobe are ignored;
- that a write in the first ready cycle is accepted;
- that the stream is not disturbed when a write arrives during busy;
- that reset in the middle of a byte clears everything.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] cfg_byte_t;
  typedef logic [CNT_W-1:0]  bit_cnt_t;
endpackage

// File: rtl/cfg_wr_detect.sv
module cfg_wr_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic cs_ni,
  input  logic wr_i,
  output logic wr_evt_o
);
  logic wr_prev_q;
  logic sel_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_prev_q <= 1'b0;
    else         wr_prev_q <= wr_i;
  end

  assign sel_ok   = cs_i & ~cs_ni;
  // only the rising strobe edge counts, so a held strobe loads once
  assign wr_evt_o = wr_i & ~wr_prev_q & sel_ok;

  AST_SINGLE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt_o |=> !wr_evt_o); // R3

endmodule

// File: rtl/cfg_ser_engine.sv
module cfg_ser_engine #(
  parameter int unsigned DATA_W    = cfg_loader_pkg::BYTE_W,
  parameter bit          MSB_FIRST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              bit_o,
  output logic              reject_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  generate
    if (MSB_FIRST) begin : g_msb
      assign bit_o   = sh_q[DATA_W-1];
      assign sh_next = {sh_q[DATA_W-2:0], 1'b0};

      AST_MSB_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_q && cnt_q != LAST |=> bit_o == $past(sh_q[DATA_W-2])); // R6
    end else begin : g_lsb
      assign bit_o   = sh_q[0];
      assign sh_next = {1'b0, sh_q[DATA_W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i && !busy_q) begin
      sh_q   <= data_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sh_q <= sh_next;
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign reject_o = load_i & busy_q;

  AST_BUSY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !busy_q |=> busy_q && cnt_q == '0); // R4
  AST_BUSY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q == LAST |=> !busy_q); // R5
  AST_LOAD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && busy_q && cnt_q != LAST |=> busy_q && cnt_q == $past(cnt_q) + 1'b1); // R7

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       cs_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       bit_o,
  output logic       bit_vld_o,
  output logic       overrun_o
);
  import cfg_loader_pkg::*;

  logic wr_evt;
  logic busy;
  logic reject;
  logic ovr_q;

  cfg_wr_detect u_wr_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .cs_ni    (cs_ni),
    .wr_i     (wr_i),
    .wr_evt_o (wr_evt)
  );

  cfg_ser_engine #(
    .DATA_W    (BYTE_W),
    .MSB_FIRST (1'b1)
  ) u_ser_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wr_evt),
    .data_i   (data_i),
    .busy_o   (busy),
    .bit_o    (bit_o),
    .reject_o (reject)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovr_q <= 1'b0;
    else if (reject) ovr_q <= 1'b1;
  end

  assign ready_o   = ~busy;
  assign bit_vld_o = busy;
  assign overrun_o = ovr_q;

  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R7
  AST_OVERRUN_ON_BUSY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt && !ready_o |=> overrun_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !wr_evt |=> ready_o && !bit_o); // R2

endmodule

// File: tb/cfg_byte_loader_bench.sv
module cfg_byte_loader_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic       cs_n = 1'b1;
  logic       wr = 1'b0;
  logic [7:0] din = '0;
  logic       ready, sbit, svld, ovr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_byte_loader u_cfg_byte_loader (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .cs_ni(cs_n), .wr_i(wr),
    .data_i(din), .ready_o(ready), .bit_o(sbit), .bit_vld_o(svld), .overrun_o(ovr)
  );

  function automatic logic exp_bit(input logic [7:0] d, input int k);
    return d[7-k];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_chk(input string req);
    chk(req, ready, 1);
    chk(req, svld, 0);
  endtask

  // called at a negedge: raises the strobe with valid selects, then checks all 8 bits
  task automatic send(input logic [7:0] d, input bit drop_wr, input int inj, input string req);
    cs = 1'b1; cs_n = 1'b0; wr = 1'b1; din = d;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk({req, "/R4"}, ready, 0);
      chk({req, "/R5"}, svld, 1);
      chk({req, "/R6"}, sbit, exp_bit(d, k));
      if (k == 0 && drop_wr) wr = 1'b0;
      if (k == inj) begin wr = 1'b1; din = ~d; end
      else if (k == inj + 1) wr = 1'b0;
    end
    @(negedge clk);
    chk({req, "/R5"}, ready, 1);
    chk({req, "/R5"}, svld, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", ready, 1); chk("R1", svld, 0); chk("R1", sbit, 0); chk("R1", ovr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1");

    send(8'hA5, 1'b1, 99, "R6");
    send(8'h3C, 1'b1, 99, "R9");   // strobe raised in the first ready cycle
    chk("R7", ovr, 0);

    // R3 held strobe
    send(8'hC3, 1'b0, 99, "R3");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      idle_chk("R3");
    end
    wr = 1'b0;
    @(negedge clk);
    chk("R3", ovr, 0);

    // R2 strobe edge with an inactive select
    cs = 1'b0; cs_n = 1'b0; wr = 1'b1; din = 8'hFF;
    @(negedge clk); wr = 1'b0; idle_chk("R2");
    @(negedge clk); idle_chk("R2");
    cs = 1'b1; cs_n = 1'b1; wr = 1'b1;
    @(negedge clk); wr = 1'b0; idle_chk("R2");
    @(negedge clk); idle_chk("R2");
    // R2 selects become valid while the strobe is already high
    cs = 1'b0; cs_n = 1'b1; wr = 1'b1;
    @(negedge clk); cs = 1'b1; cs_n = 1'b0;
    @(negedge clk); idle_chk("R2");
    @(negedge clk); idle_chk("R2");
    wr = 1'b0;
    @(negedge clk); idle_chk("R2");
    chk("R2", ovr, 0);

    // R7 write while busy
    send(8'h96, 1'b1, 3, "R7");
    chk("R7", ovr, 1);
    repeat (3) @(negedge clk);
    chk("R7", ovr, 1);
    send(8'h5A, 1'b1, 99, "R7");
    chk("R7", ovr, 1);

    // R8 reset in the middle of a byte
    cs = 1'b1; cs_n = 1'b0; wr = 1'b1; din = 8'hF0;
    @(negedge clk); wr = 1'b0;
    @(negedge clk); chk("R8", ready, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8", ready, 1); chk("R8", svld, 0); chk("R8", ovr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R8");

    // random traffic
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      int gap;
      d = 8'($urandom);
      gap = int'($urandom % 4);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        idle_chk("R5");
      end
      if ($urandom % 4 != 0) begin
        send(d, 1'b1, 99, "R6");
      end else begin
        cs = 1'($urandom % 2); cs_n = ~cs; cs_n = cs ? 1'b1 : 1'b0;
        wr = 1'b1; din = d;
        @(negedge clk); wr = 1'b0; idle_chk("R2");
        @(negedge clk); idle_chk("R2");
      end
    end
    chk("R7", ovr, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule